// File: doc/BRIEF.md
# Selectable Per-Lane Event Counter

This block is a diagnostic counter for a multi-lane serial link controller. The protocol logic drives a flat vector of one-cycle strobes, one strobe per (lane, group, event) position. Software picks a single position through a 32-bit control word and the block counts pulses on that strobe alone. The count is read back from a separate read-only data word.

The control word carries four things: the selection fields (group, event number within the group, and lane), a 3-bit enable command and a 2-bit clear command. The command fields are codes, not flag bits. Only specific values act, and every other value leaves the current state alone. Enabling never resets the count; the count returns to zero only when a clear is requested. The control word returns a status bit that shows whether counting is running.

The register bus is a plain write strobe with an address and write data. The read data follows the address combinationally.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset, the control word (offset 0x08) reads 0, the data word (offset 0x0C) reads 0, and counting is off.
- R2: While counting is on, the count rises by one at each clock edge where strobe bit `(lane*NUM_GROUPS + group)*EVTS_PER_GROUP + event` is high. Here group is control bits 27:24 and event is control bits 23:16. No other strobe bit changes the count.
- R3: Control bits 11:8 choose the lane. A lane value at or above NUM_LANES counts nothing.
- R4: Enable command field, bits 4:2:
  - Code 3 turns counting on from the next cycle, and code 1 turns it off.
  - Any other code leaves the on/off state as it was.
  - While counting is off, the count holds.
- R5: Clear command field, bits 1:0:
  - Code 1 sets the count to zero at the write edge.
  - Other codes do nothing to the count.
  - Turning counting on does not change the count.
- R6: Control bit 7 reads 1 while counting is on and 0 while it is off. Writes to bit 7 have no effect.
- R7: The count wraps to zero after reaching 2^CNT_W-1. The default CNT_W is 32.
- R8: A single write carrying clear code 1 and enable code 3 leaves the count at 0 after that edge. Counting begins with strobes in the following cycle.
- R9: A group value of NUM_GROUPS or more, or an event value of EVTS_PER_GROUP or more, counts nothing.
- R10: The address map is fixed:
  - Offset 0x08 is the control word and offset 0x0C is the data word.
  - Writes to 0x0C, or to any other offset, change nothing.
  - Reads of any other offset return 0.
  - The command fields and unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_strobe | input | NUM_LANES*NUM_GROUPS*EVTS_PER_GROUP | Per-lane, per-event pulse strobes |

## Verification
Four kinds of strobe pattern are used:
- A one-hot pattern on the selected bit shows that the chosen position is counted.
- An all-ones pattern with only the selected bit cleared shows that no neighbouring bit leaks into the count.
- All-ones patterns held under out-of-range lane, group and event values tell a correct block apart from one that aliases the index.
- Random strobe vectors mixed with random command codes (including codes that should do nothing) compare the count every cycle against a bench model.

Same-cycle clear with enable, and a run through the wrap point, pin down the edge ordering.

// File: rtl/lec_pkg.sv
package lec_pkg;
    localparam logic [7:0] ADDR_CTRL = 8'h08;
    localparam logic [7:0] ADDR_DATA = 8'h0C;
    localparam logic [2:0] EN_ON     = 3'd3;
    localparam logic [2:0] EN_OFF    = 3'd1;
    localparam logic [1:0] CLR_GO    = 2'd1;

    typedef struct packed {
        logic [3:0] grp;
        logic [7:0] evn;
        logic [3:0] lane;
        logic       act;
    } ctrl_t;
endpackage

// File: rtl/lec_ctrl.sv
module lec_ctrl
    import lec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wen,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output ctrl_t       ctrl,
    output logic        clr
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        clr    = 1'b0;
        if (wen && addr == ADDR_CTRL) begin
            ctrl_d.grp  = wdata[27:24];
            ctrl_d.evn  = wdata[23:16];
            ctrl_d.lane = wdata[11:8];
            case (wdata[4:2])
                EN_ON:   ctrl_d.act = 1'b1;
                EN_OFF:  ctrl_d.act = 1'b0;
                default: ctrl_d.act = ctrl_q.act;
            endcase
            clr = (wdata[1:0] == CLR_GO);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/lec_sel.sv
module lec_sel #(
    parameter int NUM_LANES      = 4,
    parameter int NUM_GROUPS     = 8,
    parameter int EVTS_PER_GROUP = 4
) (
    input  logic [NUM_LANES*NUM_GROUPS*EVTS_PER_GROUP-1:0] strobe,
    input  logic [3:0] grp,
    input  logic [7:0] evn,
    input  logic [3:0] lane,
    output logic       hit
);
    localparam int PER_LANE = NUM_GROUPS * EVTS_PER_GROUP;
    localparam int SW       = (PER_LANE > 1) ? $clog2(PER_LANE) : 1;
    localparam int LW       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam logic [31:0] NL_U  = 32'(NUM_LANES);
    localparam logic [31:0] NG_U  = 32'(NUM_GROUPS);
    localparam logic [31:0] EPG_U = 32'(EVTS_PER_GROUP);

    logic [31:0]          slot;
    logic [SW-1:0]        slot_idx;
    logic [LW-1:0]        lane_idx;
    logic [NUM_LANES-1:0] lane_hit;
    logic                 sel_ok;

    always_comb begin
        slot     = 32'(grp) * EPG_U + 32'(evn);
        slot_idx = slot[SW-1:0];
        lane_idx = lane[LW-1:0];
        sel_ok   = (32'(grp) < NG_U) && (32'(evn) < EPG_U) && (32'(lane) < NL_U);
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [PER_LANE-1:0] slice;
        assign slice       = strobe[l*PER_LANE +: PER_LANE];
        assign lane_hit[l] = slice[slot_idx];
    end

    assign hit = sel_ok && lane_hit[lane_idx];
endmodule

// File: rtl/lec_count.sv
module lec_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
    import lec_pkg::*;
#(
    parameter int NUM_LANES      = 4,
    parameter int NUM_GROUPS     = 8,
    parameter int EVTS_PER_GROUP = 4,
    parameter int CNT_W          = 32,
    localparam int STROBE_W      = NUM_LANES * NUM_GROUPS * EVTS_PER_GROUP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wen,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [STROBE_W-1:0] evt_strobe
);
    ctrl_t            ctrl;
    logic             clr;
    logic             hit;
    logic             act_w;
    logic [3:0]       lane_w;
    logic [CNT_W-1:0] cnt_w;

    lec_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (bus_wen),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ctrl  (ctrl),
        .clr   (clr)
    );

    lec_sel #(
        .NUM_LANES      (NUM_LANES),
        .NUM_GROUPS     (NUM_GROUPS),
        .EVTS_PER_GROUP (EVTS_PER_GROUP)
    ) u_sel (
        .strobe (evt_strobe),
        .grp    (ctrl.grp),
        .evn    (ctrl.evn),
        .lane   (ctrl.lane),
        .hit    (hit)
    );

    lec_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (hit && ctrl.act),
        .count (cnt_w)
    );

    assign act_w  = ctrl.act;
    assign lane_w = ctrl.lane;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {4'b0, ctrl.grp, ctrl.evn, 4'b0, ctrl.lane, ctrl.act, 7'b0};
            ADDR_DATA: bus_rdata[CNT_W-1:0] = cnt_w;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

module lec_chk #(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wen,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             act,
    input logic [3:0]       lane,
    input logic [CNT_W-1:0] cnt
);
    logic ctl_wr;
    assign ctl_wr = bus_wen && (bus_addr == 8'h08);

    a_r4_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && bus_wdata[4:2] == 3'd3 |=> act);
    a_r4_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && bus_wdata[4:2] == 3'd1 |=> !act);
    a_r4_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && bus_wdata[4:2] != 3'd3 && bus_wdata[4:2] != 3'd1 |=> $stable(act));
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !act && !ctl_wr |=> $stable(cnt));
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && bus_wdata[1:0] == 2'd1 |=> cnt == '0);
    a_r3_bad_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr && 32'(lane) >= 32'(NUM_LANES) |=> $stable(cnt));
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && bus_wdata[1:0] == 2'd1) |=>
        (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));
    a_r6_status: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h08 |-> bus_rdata[7] == act);
    a_r8_clear_and_on: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && bus_wdata[1:0] == 2'd1 && bus_wdata[4:2] == 3'd3 |=> act && cnt == '0);
endmodule

bind lane_evt_counter lec_chk #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .act       (act_w),
    .lane      (lane_w),
    .cnt       (cnt_w)
);

// File: tb/sim_lane_evt_counter.sv
`timescale 1ns/1ps
module sim_lane_evt_counter;
    localparam int NL = 4, NG = 8, EPG = 4, CW = 10;
    localparam int SW = NL * NG * EPG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wen = 1'b0;
    logic [7:0]    bus_addr = 8'h0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [SW-1:0] evt_strobe = '0;

    int n_run = 0, n_fail = 0;

    logic [3:0]    m_grp = '0;
    logic [7:0]    m_evn = '0;
    logic [3:0]    m_lane = '0;
    logic          m_act = 1'b0;
    logic [CW-1:0] m_cnt = '0;

    always #4 clk = ~clk;

    lane_evt_counter #(
        .NUM_LANES(NL), .NUM_GROUPS(NG), .EVTS_PER_GROUP(EPG), .CNT_W(CW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt_strobe)
    );

    function automatic logic [31:0] mk(logic [3:0] g, logic [7:0] e, logic [3:0] l,
                                       logic [2:0] en, logic [1:0] c);
        return {4'b0, g, e, 4'b0, l, 3'b000, en, c};
    endfunction

    function automatic logic [31:0] ctrl_exp();
        return {4'b0, m_grp, m_evn, 4'b0, m_lane, m_act, 7'b0};
    endfunction

    function automatic logic [SW-1:0] one_at(int idx);
        logic [SW-1:0] v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    task automatic cyc(input logic [SW-1:0] s, input logic w, input logic [7:0] a,
                       input logic [31:0] d);
        logic hit;
        evt_strobe = s; bus_wen = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        hit = 1'b0;
        if (m_act && m_lane < NL && m_grp < NG && m_evn < EPG)
            hit = s[(int'(m_lane) * NG + int'(m_grp)) * EPG + int'(m_evn)];
        if (w && a == 8'h08) begin
            if (d[1:0] == 2'd1) m_cnt = '0;
            else if (hit)       m_cnt = m_cnt + 1'b1;
            m_grp = d[27:24]; m_evn = d[23:16]; m_lane = d[11:8];
            if (d[4:2] == 3'd3)      m_act = 1'b1;
            else if (d[4:2] == 3'd1) m_act = 1'b0;
        end else if (hit) begin
            m_cnt = m_cnt + 1'b1;
        end
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        n_run++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [SW-1:0] ones;
        ones = '1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", 8'h08, 32'h0);
        chk("R1", 8'h0C, 32'h0);

        // R10 address map
        chk("R10", 8'h04, 32'h0);
        cyc(ones, 1'b1, 8'h0C, 32'hFFFF_FFFF);
        chk("R10", 8'h0C, 32'h0);
        cyc('0, 1'b1, 8'h10, mk(4'd1, 8'd1, 4'd1, 3'd3, 2'd0));
        chk("R10", 8'h08, 32'h0);

        // R6 status bit is not writable
        cyc('0, 1'b1, 8'h08, 32'h0000_0080);
        chk("R6", 8'h08, ctrl_exp());

        // R2 one-hot on selected bit, then all-but-selected
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd3, 2'd0));
        chk("R6", 8'h08, ctrl_exp());
        for (int i = 0; i < 5; i++) cyc(one_at(43), 1'b0, 8'h0C, 32'h0);
        for (int i = 0; i < 3; i++) cyc(ones & ~one_at(43), 1'b0, 8'h0C, 32'h0);
        chk("R2", 8'h0C, 32'd5);

        // R4 other code holds, off stops, idle holds
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd5, 2'd0));
        chk("R4", 8'h08, ctrl_exp());
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd1, 2'd0));
        for (int i = 0; i < 3; i++) cyc(ones, 1'b0, 8'h0C, 32'h0);
        chk("R4", 8'h0C, 32'd5);
        chk("R6", 8'h08, ctrl_exp());

        // R5 enabling keeps the count; clear codes
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd3, 2'd0));
        chk("R5", 8'h0C, 32'd5);
        for (int i = 0; i < 2; i++) cyc(one_at(43), 1'b0, 8'h0C, 32'h0);
        chk("R5", 8'h0C, 32'd7);
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd0, 2'd2));
        chk("R5", 8'h0C, 32'd7);
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd0, 2'd1));
        chk("R5", 8'h0C, 32'd0);

        // R8 clear with enable in the same write
        cyc(one_at(43), 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd1, 2'd0));
        cyc(one_at(43), 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd1, 3'd3, 2'd1));
        chk("R8", 8'h0C, 32'd0);
        cyc(one_at(43), 1'b0, 8'h0C, 32'h0);
        chk("R8", 8'h0C, 32'd1);

        // R3 lane out of range, then highest valid lane
        cyc('0, 1'b1, 8'h08, mk(4'd2, 8'd3, 4'd5, 3'd3, 2'd1));
        for (int i = 0; i < 4; i++) cyc(ones, 1'b0, 8'h0C, 32'h0);
        chk("R3", 8'h0C, 32'd0);
        cyc('0, 1'b1, 8'h08, mk(4'd0, 8'd0, 4'd3, 3'd3, 2'd1));
        for (int i = 0; i < 3; i++) cyc(one_at(96), 1'b0, 8'h0C, 32'h0);
        chk("R3", 8'h0C, 32'd3);

        // R9 group or event out of range
        cyc('0, 1'b1, 8'h08, mk(4'd9, 8'd0, 4'd0, 3'd3, 2'd1));
        for (int i = 0; i < 4; i++) cyc(ones, 1'b0, 8'h0C, 32'h0);
        chk("R9", 8'h0C, 32'd0);
        cyc('0, 1'b1, 8'h08, mk(4'd1, 8'd6, 4'd0, 3'd3, 2'd1));
        for (int i = 0; i < 4; i++) cyc(ones, 1'b0, 8'h0C, 32'h0);
        chk("R9", 8'h0C, 32'd0);

        // R7 wrap at 2^CW
        cyc('0, 1'b1, 8'h08, mk(4'd7, 8'd3, 4'd0, 3'd3, 2'd1));
        for (int i = 0; i < (1 << CW) - 1; i++) cyc(one_at(31), 1'b0, 8'h0C, 32'h0);
        chk("R7", 8'h0C, 32'((1 << CW) - 1));
        cyc(one_at(31), 1'b0, 8'h0C, 32'h0);
        chk("R7", 8'h0C, 32'd0);

        // R2 random strobes with random command writes
        for (int i = 0; i < 3000; i++) begin
            logic [SW-1:0] s;
            logic          w;
            logic [31:0]   d;
            for (int k = 0; k < SW / 32; k++) s[k*32 +: 32] = $urandom;
            w = ($urandom % 16) == 0;
            d = mk(4'($urandom % 10), 8'($urandom % 6), 4'($urandom % 6),
                   3'($urandom), 2'($urandom)) | ($urandom & 32'h80);
            cyc(s, w, w ? 8'h08 : 8'h0C, d);
            chk("R2", 8'h0C, 32'(m_cnt));
            if (w) chk("R6", 8'h08, ctrl_exp());
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule